// File: doc/BRIEF.md
# Switchable Dual Data Pointer

This block holds two 16-bit data pointers for an 8-bit microcontroller core and uses a one-bit select flag to choose which of them the core addresses through. The core reaches the pointers over a byte-wide special-function-register (SFR) port. The currently selected pointer appears as a 16-bit output for memory addressing. An increment strobe advances the selected pointer by one.

A build parameter picks one of two arrangements. In the split arrangement, each pointer has its own pair of SFR byte addresses, and the select flag only decides which pointer drives the output and takes increments. In the shared arrangement, the two pointers share a single visible byte pair. When the select flag changes value, the visible contents are saved into the shadow slot that belongs to the pointer being left. The visible pair is then loaded from the shadow slot of the pointer being entered. Writing the flag with its current value leaves everything as it is.

Top module: `dual_dptr`

## Requirements
- R1: After synchronous active-low reset, both pointers, both shadow slots and the select flag are zero. `ptr_out` and `ptr_sel` read 0, and a read of the select register at 0xA2 returns 0x00.
- R2: The select flag is bit 0 of the register at SFR address 0xA2. A write loads bit 0 of the data. Bits 7..1 are ignored and read back as 0.
- R3: In the split arrangement, pointer 0 has its low byte at 0x82 and its high byte at 0x83. Pointer 1 has its low byte at 0x84 and its high byte at 0x85. Each byte can be written and read back at its own address whatever the select flag holds.
- R4: In the split arrangement, `ptr_out` shows pointer 0 when the flag is 0 and pointer 1 when the flag is 1. The increment strobe changes only that selected pointer.
- R5: In the shared arrangement, only 0x82 (low) and 0x83 (high) are decoded, and they access the visible pair. Addresses 0x84 and 0x85 give `sfr_hit` = 0 and read 0, and writes to them change nothing.
- R6: In the shared arrangement, a write to 0xA2 that leaves the flag at its current value does not change the visible pair.
- R7: In the shared arrangement, a write that changes the flag stores the visible pair into the shadow slot of the previous selection. In the same cycle it loads the visible pair from the shadow slot of the new selection. The result shows from the next cycle.
- R8: Each increment strobe adds one to the selected pointer modulo 2^16, so 0xFFFF becomes 0x0000.
- R9: In the shared arrangement, an increment in the same cycle as a flag change acts on the newly loaded value. The value saved for the previous selection is the value before the increment.
- R10: A write to a byte of a pointer in the same cycle as an increment of that pointer takes priority. The written byte takes the write data, the other byte keeps its value, and the increment is dropped.
- R11: `sfr_hit` is 1 exactly when `sfr_addr` is a register decoded in the built arrangement. `sfr_rdata` is 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wr | input | 1 | Write strobe for `sfr_addr` |
| sfr_wdata | input | 8 | Write data |
| sfr_hit | output | 1 | Address is decoded by this block |
| sfr_rdata | output | 8 | Read data for `sfr_addr`, combinational |
| ptr_inc | input | 1 | Advance the selected pointer by one |
| ptr_out | output | 16 | Selected pointer value |
| ptr_sel | output | 1 | Current select flag |

## Verification
The hardest situation to produce in the shared arrangement is a flag change in the same cycle as an increment. It is hard because the saved value and the loaded value must both be observed, and the ports show only the visible pair. The bench first loads distinct values into both shadow slots through ordered writes and swaps. It then applies a swap with the increment strobe asserted. After that it swaps back and forth again, so that both the incremented visible value and the untouched saved value appear on `ptr_out`. The write-over-increment priority is reached by asserting the increment strobe on the same cycle as a high-byte write, starting from a pointer whose low byte would otherwise carry.

// File: rtl/dptr_pkg.sv
// Package: shared widths, types and helpers for the dual data pointer.
// Assumes an 8-bit SFR bus and 16-bit pointers built from two bytes.
package dptr_pkg;

    localparam int DPTR_BYTE_W = 8;
    localparam int DPTR_W      = 2 * DPTR_BYTE_W;
    localparam int DPTR_NUM    = 2;

    typedef logic [DPTR_BYTE_W-1:0] sfr_byte_t;
    typedef logic [DPTR_W-1:0]      dptr_t;
    typedef logic [DPTR_NUM-1:0]    dptr_mask_t;

    typedef enum logic {
        SEL_PTR0 = 1'b0,
        SEL_PTR1 = 1'b1
    } dptr_sel_e;

    // Replace the addressed bytes of a pointer with write data.
    function automatic dptr_t dptr_merge(input dptr_t cur, input logic wr_lo,
                                         input logic wr_hi, input sfr_byte_t d);
        dptr_t res;
        res = cur;
        if (wr_lo) res[DPTR_BYTE_W-1:0]      = d;
        if (wr_hi) res[DPTR_W-1:DPTR_BYTE_W] = d;
        return res;
    endfunction

    // Next value of a pointer under increment, wrapping at the top.
    function automatic dptr_t dptr_bump(input dptr_t cur);
        return cur + dptr_t'(1);
    endfunction

endpackage

// File: rtl/dptr_sfr_decode.sv
// Module: SFR address decoder for the dual data pointer.
// Flags which register an address selects and gates the write strobe.
// In shared mode (SHARED=1) the second pointer's addresses are not decoded.
module dptr_sfr_decode
    import dptr_pkg::*;
#(
    parameter bit        SHARED  = 1'b0,
    parameter sfr_byte_t SEL_ADR = 8'hA2,
    parameter sfr_byte_t P0L_ADR = 8'h82,
    parameter sfr_byte_t P0H_ADR = 8'h83,
    parameter sfr_byte_t P1L_ADR = 8'h84,
    parameter sfr_byte_t P1H_ADR = 8'h85
) (
    input  sfr_byte_t  addr,
    input  logic       wr,
    output logic       hit,
    output logic       sel_hit,
    output logic       sel_wr,
    output dptr_mask_t lo_hit,
    output dptr_mask_t hi_hit,
    output dptr_mask_t lo_wr,
    output dptr_mask_t hi_wr
);

    localparam sfr_byte_t LO_ADR [DPTR_NUM] = '{P0L_ADR, P1L_ADR};
    localparam sfr_byte_t HI_ADR [DPTR_NUM] = '{P0H_ADR, P1H_ADR};

    // Select register match.
    assign sel_hit = (addr == SEL_ADR);
    assign sel_wr  = sel_hit & wr;

    // Per-pointer byte matches; pointer 1 is absent when shared.
    for (genvar g = 0; g < DPTR_NUM; g++) begin : g_ptr
        if (SHARED && g != 0) begin : g_off
            assign lo_hit[g] = 1'b0;
            assign hi_hit[g] = 1'b0;
        end else begin : g_on
            assign lo_hit[g] = (addr == LO_ADR[g]);
            assign hi_hit[g] = (addr == HI_ADR[g]);
        end
    end

    assign lo_wr = lo_hit & {DPTR_NUM{wr}};
    assign hi_wr = hi_hit & {DPTR_NUM{wr}};
    assign hit   = sel_hit | (|lo_hit) | (|hi_hit);

endmodule

// File: rtl/dptr_select_reg.sv
// Module: one-bit pointer select register.
// Holds the select flag and reports a write that changes its value.
// Assumes sel_wr is already gated by the address decode.
module dptr_select_reg
    import dptr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_wr,
    input  logic      wbit,
    output dptr_sel_e sel_q,
    output logic      sel_chg
);

    // Capture bit 0 of the write data on a select write.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= SEL_PTR0;
        else if (sel_wr) sel_q <= dptr_sel_e'(wbit);
    end

    // Change request: a write carrying the opposite value.
    assign sel_chg = sel_wr & (wbit != sel_q);

    assert_sel_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel_q == dptr_sel_e'($past(wbit))));

    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(sel_q));

endmodule

// File: rtl/dptr_store_split.sv
// Module: pointer storage for the split arrangement.
// Each pointer has its own registers; the select only steers the increment.
// A byte write to a pointer overrides an increment of that pointer.
module dptr_store_split
    import dptr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  dptr_sel_e                 sel_q,
    input  logic                      inc,
    input  dptr_mask_t                lo_wr,
    input  dptr_mask_t                hi_wr,
    input  sfr_byte_t                 wdata,
    output logic [DPTR_NUM-1:0][DPTR_W-1:0] view,
    output dptr_t                     active
);

    logic [DPTR_NUM-1:0][DPTR_W-1:0] ptr_q;

    for (genvar g = 0; g < DPTR_NUM; g++) begin : g_ptr
        // Update one pointer: write first, else increment when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[g] <= '0;
            else if (lo_wr[g] | hi_wr[g])
                ptr_q[g] <= dptr_merge(ptr_q[g], lo_wr[g], hi_wr[g], wdata);
            else if (inc && sel_q == dptr_sel_e'(g))
                ptr_q[g] <= dptr_bump(ptr_q[g]);
        end

        assert_wr_over_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (lo_wr[g] && !hi_wr[g]) |=>
                (ptr_q[g][DPTR_W-1:DPTR_BYTE_W] == $past(ptr_q[g][DPTR_W-1:DPTR_BYTE_W])));

        assert_unselected_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q != dptr_sel_e'(g) && !lo_wr[g] && !hi_wr[g]) |=> $stable(ptr_q[g]));
    end

    assign view   = ptr_q;
    assign active = ptr_q[sel_q];

endmodule

// File: rtl/dptr_store_shared.sv
// Module: pointer storage for the shared arrangement.
// One visible pair plus a shadow slot per pointer. A select change saves the
// visible pair into the old slot and loads the visible pair from the new one.
// Assumes at most one SFR write per cycle, so a write never meets a swap.
module dptr_store_shared
    import dptr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  dptr_sel_e                 sel_q,
    input  logic                      sel_wr,
    input  logic                      sel_chg,
    input  logic                      inc,
    input  dptr_mask_t                lo_wr,
    input  dptr_mask_t                hi_wr,
    input  sfr_byte_t                 wdata,
    output logic [DPTR_NUM-1:0][DPTR_W-1:0] view,
    output dptr_t                     active
);

    dptr_t                           vis_q;
    logic [DPTR_NUM-1:0][DPTR_W-1:0] shadow_q;
    dptr_t                           base;
    dptr_t                           vis_d;
    dptr_sel_e                       sel_new;

    assign sel_new = dptr_sel_e'(~sel_q);

    // Source of the next visible value: swapped-in shadow or current value.
    always_comb begin
        base = sel_chg ? shadow_q[sel_new] : vis_q;
        if (lo_wr[0] | hi_wr[0])
            vis_d = dptr_merge(vis_q, lo_wr[0], hi_wr[0], wdata);
        else if (inc)
            vis_d = dptr_bump(base);
        else
            vis_d = base;
    end

    // Visible pair register.
    always_ff @(posedge clk) begin
        if (!rst_n) vis_q <= '0;
        else        vis_q <= vis_d;
    end

    for (genvar g = 0; g < DPTR_NUM; g++) begin : g_shadow
        // Save the visible pair into the slot being left.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[g] <= '0;
            else if (sel_chg && sel_q == dptr_sel_e'(g))
                shadow_q[g] <= vis_q;
        end
    end

    assign view[0] = vis_q;
    for (genvar g = 1; g < DPTR_NUM; g++) begin : g_view
        assign view[g] = '0;
    end
    assign active = vis_q;

    assert_no_swap_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !sel_chg && !inc) |=> $stable(vis_q));

    assert_save_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (shadow_q[$past(sel_q)] == $past(vis_q)));

    assert_load_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_chg && !inc) |=> (vis_q == $past(shadow_q[sel_new])));

    assert_swap_then_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_chg && inc) |=> (vis_q == dptr_bump($past(shadow_q[sel_new]))));

endmodule

// File: rtl/dual_dptr.sv
// Module: switchable dual data pointer (top).
// Decodes the SFR port, holds the select flag and instantiates the storage
// variant picked by SHARED. Read data is combinational from the registers.
module dual_dptr
    import dptr_pkg::*;
#(
    parameter bit        SHARED  = 1'b0,
    parameter sfr_byte_t SEL_ADR = 8'hA2,
    parameter sfr_byte_t P0L_ADR = 8'h82,
    parameter sfr_byte_t P0H_ADR = 8'h83,
    parameter sfr_byte_t P1L_ADR = 8'h84,
    parameter sfr_byte_t P1H_ADR = 8'h85
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  sfr_addr,
    input  logic        sfr_wr,
    input  logic [7:0]  sfr_wdata,
    output logic        sfr_hit,
    output logic [7:0]  sfr_rdata,
    input  logic        ptr_inc,
    output logic [15:0] ptr_out,
    output logic        ptr_sel
);

    logic                            sel_hit;
    logic                            sel_wr;
    logic                            sel_chg;
    dptr_sel_e                       sel_q;
    dptr_mask_t                      lo_hit;
    dptr_mask_t                      hi_hit;
    dptr_mask_t                      lo_wr;
    dptr_mask_t                      hi_wr;
    logic [DPTR_NUM-1:0][DPTR_W-1:0] view;
    dptr_t                           active;

    dptr_sfr_decode #(
        .SHARED (SHARED),  .SEL_ADR(SEL_ADR),
        .P0L_ADR(P0L_ADR), .P0H_ADR(P0H_ADR),
        .P1L_ADR(P1L_ADR), .P1H_ADR(P1H_ADR)
    ) u_decode (
        .addr   (sfr_addr), .wr    (sfr_wr),   .hit   (sfr_hit),
        .sel_hit(sel_hit),  .sel_wr(sel_wr),
        .lo_hit (lo_hit),   .hi_hit(hi_hit),   .lo_wr (lo_wr), .hi_wr(hi_wr)
    );

    dptr_select_reg u_select (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .wbit(sfr_wdata[0]),
        .sel_q(sel_q), .sel_chg(sel_chg)
    );

    if (SHARED) begin : g_shared
        dptr_store_shared u_store (
            .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .sel_wr(sel_wr),
            .sel_chg(sel_chg), .inc(ptr_inc), .lo_wr(lo_wr), .hi_wr(hi_wr),
            .wdata(sfr_wdata), .view(view), .active(active)
        );
    end else begin : g_split
        dptr_store_split u_store (
            .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .inc(ptr_inc),
            .lo_wr(lo_wr), .hi_wr(hi_wr), .wdata(sfr_wdata),
            .view(view), .active(active)
        );
    end

    // Read mux: select register or the addressed pointer byte, else zero.
    always_comb begin
        sfr_rdata = '0;
        if (sel_hit) sfr_rdata = {{(DPTR_BYTE_W-1){1'b0}}, sel_q};
        for (int i = 0; i < DPTR_NUM; i++) begin
            if (lo_hit[i]) sfr_rdata = view[i][DPTR_BYTE_W-1:0];
            if (hi_hit[i]) sfr_rdata = view[i][DPTR_W-1:DPTR_BYTE_W];
        end
    end

    assign ptr_out = active;
    assign ptr_sel = sel_q;

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && ptr_out == 16'hFFFF && !sfr_wr) |=> (ptr_out == 16'h0000));

    assert_inc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !sfr_wr) |=> (ptr_out == 16'($past(ptr_out) + 16'd1)));

    assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_hit |-> (sfr_rdata == 8'h00));

endmodule

// File: tb/test_dual_dptr.sv
// Directed bench: one split-arrangement and one shared-arrangement instance.
module test_dual_dptr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  s_addr = 8'h00, h_addr = 8'h00;
    logic        s_wr = 1'b0, h_wr = 1'b0;
    logic [7:0]  s_wd = 8'h00, h_wd = 8'h00;
    logic        s_inc = 1'b0, h_inc = 1'b0;
    logic        s_hit, h_hit;
    logic [7:0]  s_rd, h_rd;
    logic [15:0] s_ptr, h_ptr;
    logic        s_sel, h_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_dptr #(.SHARED(1'b0)) i_dual_dptr (
        .clk(clk), .rst_n(rst_n), .sfr_addr(s_addr), .sfr_wr(s_wr),
        .sfr_wdata(s_wd), .sfr_hit(s_hit), .sfr_rdata(s_rd),
        .ptr_inc(s_inc), .ptr_out(s_ptr), .ptr_sel(s_sel)
    );

    dual_dptr #(.SHARED(1'b1)) i_dual_dptr_shared (
        .clk(clk), .rst_n(rst_n), .sfr_addr(h_addr), .sfr_wr(h_wr),
        .sfr_wdata(h_wd), .sfr_hit(h_hit), .sfr_rdata(h_rd),
        .ptr_inc(h_inc), .ptr_out(h_ptr), .ptr_sel(h_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus; results are visible when it returns.
    task automatic cyc(input bit hid, input logic [7:0] a, input bit w,
                       input logic [7:0] d, input bit inc);
        @(negedge clk);
        if (hid) begin h_addr = a; h_wr = w; h_wd = d; h_inc = inc; end
        else     begin s_addr = a; s_wr = w; s_wd = d; s_inc = inc; end
        @(negedge clk);
        s_wr = 1'b0; s_inc = 1'b0; h_wr = 1'b0; h_inc = 1'b0;
    endtask

    task automatic rd(input bit hid, input logic [7:0] a, output logic hit, output logic [7:0] d);
        if (hid) h_addr = a; else s_addr = a;
        #1;
        hit = hid ? h_hit : s_hit;
        d   = hid ? h_rd  : s_rd;
    endtask

    task automatic t_reset;
        logic h; logic [7:0] d;
        chk("R1 split ptr", s_ptr, 16'h0000);
        chk("R1 shared ptr", h_ptr, 16'h0000);
        chk("R1 sel", {s_sel, h_sel}, 2'b00);
        rd(0, 8'hA2, h, d); chk("R1 sel read", {h, d}, {1'b1, 8'h00});
        rd(1, 8'h83, h, d); chk("R1 shared hi read", {h, d}, {1'b1, 8'h00});
    endtask

    task automatic t_sel_reg;
        logic h; logic [7:0] d;
        cyc(0, 8'hA2, 1, 8'hFF, 0);
        rd(0, 8'hA2, h, d); chk("R2 upper bits read 0", d, 8'h01);
        cyc(0, 8'hA2, 1, 8'hFE, 0);
        rd(0, 8'hA2, h, d); chk("R2 bit0 clears", d, 8'h00);
    endtask

    task automatic t_split_rw;
        logic h; logic [7:0] d;
        cyc(0, 8'h82, 1, 8'h12, 0); cyc(0, 8'h83, 1, 8'h34, 0);
        cyc(0, 8'h84, 1, 8'h56, 0); cyc(0, 8'h85, 1, 8'h78, 0);
        cyc(0, 8'hA2, 1, 8'h01, 0);
        rd(0, 8'h82, h, d); chk("R3 p0 lo", d, 8'h12);
        rd(0, 8'h83, h, d); chk("R3 p0 hi", d, 8'h34);
        rd(0, 8'h84, h, d); chk("R3 p1 lo", d, 8'h56);
        rd(0, 8'h85, h, d); chk("R3 p1 hi", {h, d}, {1'b1, 8'h78});
    endtask

    task automatic t_split_steer;
        logic h; logic [7:0] d;
        chk("R4 sel1 out", s_ptr, 16'h7856);
        cyc(0, 8'h00, 0, 8'h00, 1);
        chk("R4 inc sel1", s_ptr, 16'h7857);
        rd(0, 8'h82, h, d); chk("R4 p0 untouched", d, 8'h12);
        cyc(0, 8'hA2, 1, 8'h00, 0);
        chk("R4 sel0 out", s_ptr, 16'h3412);
    endtask

    task automatic t_decode;
        logic h; logic [7:0] d;
        cyc(1, 8'h84, 1, 8'hAB, 0);
        rd(1, 8'h84, h, d); chk("R5 shared 84 miss", {h, d}, {1'b0, 8'h00});
        rd(1, 8'h85, h, d); chk("R5 shared 85 miss", {h, d}, {1'b0, 8'h00});
        chk("R5 write ignored", h_ptr, 16'h0000);
        rd(0, 8'h90, h, d); chk("R11 split miss", {h, d}, {1'b0, 8'h00});
    endtask

    task automatic t_noswap;
        cyc(1, 8'h82, 1, 8'hAA, 0); cyc(1, 8'h83, 1, 8'hBB, 0);
        cyc(1, 8'hA2, 1, 8'h00, 0);
        chk("R6 same 0 no swap", h_ptr, 16'hBBAA);
    endtask

    task automatic t_swap;
        cyc(1, 8'hA2, 1, 8'h01, 0);
        chk("R7 load empty slot", h_ptr, 16'h0000);
        cyc(1, 8'h82, 1, 8'h11, 0); cyc(1, 8'h83, 1, 8'h22, 0);
        cyc(1, 8'hA2, 1, 8'h03, 0);
        chk("R6 same 1 no swap", h_ptr, 16'h2211);
        cyc(1, 8'hA2, 1, 8'h00, 0);
        chk("R7 restore slot0", h_ptr, 16'hBBAA);
        cyc(1, 8'hA2, 1, 8'h01, 0);
        chk("R7 restore slot1", h_ptr, 16'h2211);
    endtask

    task automatic t_swap_inc;
        cyc(1, 8'hA2, 1, 8'h00, 1);
        chk("R9 inc on loaded", h_ptr, 16'hBBAB);
        cyc(1, 8'hA2, 1, 8'h01, 0);
        chk("R9 saved pre-inc", h_ptr, 16'h2211);
        cyc(1, 8'hA2, 1, 8'h00, 0);
        chk("R9 incremented kept", h_ptr, 16'hBBAB);
    endtask

    task automatic t_wrap;
        cyc(0, 8'h82, 1, 8'hFF, 0); cyc(0, 8'h83, 1, 8'hFF, 0);
        cyc(0, 8'h00, 0, 8'h00, 1);
        chk("R8 split wrap", s_ptr, 16'h0000);
        cyc(1, 8'h82, 1, 8'hFF, 0); cyc(1, 8'h83, 1, 8'hFF, 0);
        cyc(1, 8'h00, 0, 8'h00, 1);
        chk("R8 shared wrap", h_ptr, 16'h0000);
    endtask

    task automatic t_wr_inc;
        cyc(0, 8'h82, 1, 8'hFF, 0);
        cyc(0, 8'h83, 1, 8'h12, 1);
        chk("R10 split write wins", s_ptr, 16'h12FF);
        cyc(1, 8'h82, 1, 8'h40, 1);
        chk("R10 shared write wins", h_ptr, 16'h0040);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_sel_reg;
        t_split_rw;
        t_split_steer;
        t_decode;
        t_noswap;
        t_swap;
        t_swap_inc;
        t_wrap;
        t_wr_inc;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule